// File: doc/BRIEF.md
# Multi-precision floating-point rounder

This block rounds one operand held in a wide internal floating-point format: a sign, a 16-bit biased exponent, a 64-bit mantissa and a 3-bit field of guard, round and sticky bits carried over from the preceding arithmetic. A 2-bit precision select picks how many mantissa bits survive: all 64, 24, or 53. A 2-bit mode select picks the rounding direction. The unit works out new guard, round and sticky bits just below the kept part of the mantissa. It then decides whether to add one unit at the last kept bit, absorbs a carry out of the mantissa into the exponent, and zeroes everything below the kept bits.

The datapath is combinational and has one register stage at the output. An operand presented with `in_valid` high appears rounded one clock later, with `out_valid` high. The result leaves with an empty guard/round/sticky field, the sign unchanged, and a flag that tells whether any discarded bit was non-zero.

Top module: `fp_round_unit`

## Requirements
- R1: Precision code 0 keeps all 64 mantissa bits, code 1 keeps the top 24 bits (the last kept bit is mantissa bit 40), and codes 2 and 3 keep the top 53 bits (the last kept bit is mantissa bit 11). Every result bit below the last kept bit is 0.
- R2: At 24-bit precision, guard is mantissa bit 39 and round is mantissa bit 38. Sticky is the OR of mantissa bits 37..0 and of all three incoming guard/round/sticky bits.
- R3: At 53-bit precision, guard is mantissa bit 10 and round is mantissa bit 9. Sticky is the OR of mantissa bits 8..0 and of the incoming guard/round/sticky bits. At 64-bit precision, the incoming field is used directly: bit 2 is guard, bit 1 is round, bit 0 is sticky.
- R4: When the recomputed guard, round and sticky are all 0, the mantissa and exponent pass unchanged and `out_inexact` is 0. Otherwise `out_inexact` is 1.
- R5: Mode 0 (to nearest) adds one at the last kept bit when guard is 1. If round and sticky are then both 0, the last kept bit is forced to 0, so ties go to even.
- R6: Mode 1 (toward zero) never increments. The exponent is unchanged and the mantissa is the input truncated at the precision.
- R7: Mode 3 (toward plus infinity) increments an inexact value with sign 0. Mode 2 (toward minus infinity) increments an inexact value with sign 1. Neither increments in any other case.
- R8: If the increment carries out of mantissa bit 63, the result mantissa is 1 followed by 63 zeros and the exponent rises by 1, wrapping modulo 2^16.
- R9: The output guard/round/sticky field is always 0, and the output sign equals the input sign.
- R10: The result appears exactly one clock after an input with `in_valid` high, together with `out_valid`. `out_valid` is 0 after reset and in every cycle that follows an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | 16 | Operand exponent |
| in_mant | input | 64 | Operand mantissa, bit 63 is the integer bit |
| in_grs | input | 3 | Incoming guard (2), round (1), sticky (0) |
| in_prec | input | 2 | Precision: 0 = 64 bits, 1 = 24 bits, 2/3 = 53 bits |
| in_mode | input | 2 | Mode: 0 nearest, 1 zero, 2 minus, 3 plus |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Result sign |
| out_exp | output | 16 | Result exponent |
| out_mant | output | 64 | Rounded mantissa |
| out_grs | output | 3 | Always zero after rounding |
| out_inexact | output | 1 | Some discarded bit was non-zero |

## Verification
Some properties are checked by assertions on every valid result:
- the sign passes through and the output guard/round/sticky field is zero;
- nothing is left below the 24-bit limit;
- an exact 64-bit input comes back unchanged;
- toward-zero mode never grows the value;
- any change of exponent comes with the power-of-two mantissa.

Other behaviour can only be shown by the bench's scenarios, compared against a reference model that rounds the 67-bit mantissa-plus-extension as an integer:
- the exact choice between increment and truncate for each mode and sign;
- ties-to-even against odd and even last kept bits;
- the guard and sticky positions at each precision;
- carries from all-ones mantissas.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W    = 16,
  parameter int MANT_W   = 64,
  parameter int SGL_KEEP = 24,
  parameter int DBL_KEEP = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [2:0]        in_grs,
  input  logic [1:0]        in_prec,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic [2:0]        out_grs,
  output logic              out_inexact
);

  localparam int SGL_LSB = MANT_W - SGL_KEEP;
  localparam int DBL_LSB = MANT_W - DBL_KEEP;

  logic [MANT_W-1:0] lsb_one, below_mask, shifted, rounded;
  logic [MANT_W:0]   sum;
  logic              g_bit, r_bit, s_bit, inexact, bump, tie, carry;
  logic [1:0]        q_prec;

  always_comb begin
    case (in_prec)
      2'd0: begin
        lsb_one = MANT_W'(1);
        g_bit   = in_grs[2];
        r_bit   = in_grs[1];
        s_bit   = in_grs[0];
      end
      2'd1: begin
        lsb_one = MANT_W'(1) << SGL_LSB;
        g_bit   = in_mant[SGL_LSB-1];
        r_bit   = in_mant[SGL_LSB-2];
        s_bit   = (|in_mant[SGL_LSB-3:0]) | (|in_grs);
      end
      default: begin
        lsb_one = MANT_W'(1) << DBL_LSB;
        g_bit   = in_mant[DBL_LSB-1];
        r_bit   = in_mant[DBL_LSB-2];
        s_bit   = (|in_mant[DBL_LSB-3:0]) | (|in_grs);
      end
    endcase
  end

  assign below_mask = lsb_one - MANT_W'(1);
  assign inexact    = g_bit | r_bit | s_bit;

  always_comb begin
    case (in_mode)
      2'd0:    bump = g_bit;
      2'd1:    bump = 1'b0;
      2'd2:    bump = inexact & in_sign;
      default: bump = inexact & ~in_sign;
    endcase
  end

  assign tie     = (in_mode == 2'd0) & g_bit & ~r_bit & ~s_bit;
  assign sum     = {1'b0, in_mant} + {1'b0, (bump ? lsb_one : '0)};
  assign carry   = sum[MANT_W];
  assign shifted = carry ? {1'b1, sum[MANT_W-1:1]} : sum[MANT_W-1:0];
  assign rounded = (tie ? (shifted & ~lsb_one) : shifted) & ~below_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_inexact <= 1'b0;
      q_prec      <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign    <= in_sign;
        out_exp     <= in_exp + {{(EXP_W-1){1'b0}}, carry};
        out_mant    <= rounded;
        out_inexact <= inexact;
        q_prec      <= in_prec;
      end
    end
  end

  assign out_grs = 3'b000;

  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sign == $past(in_sign)) && (out_grs == 3'b000)); // R9
  AST_SGL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_prec == 2'd1) |-> (out_mant[SGL_LSB-1:0] == '0)); // R1
  AST_EXACT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_prec) == 2'd0 && $past(in_grs) == 3'b000)
      |-> (out_mant == $past(in_mant)) && (out_exp == $past(in_exp)) && !out_inexact); // R4
  AST_ZERO_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_mode) == 2'd1)
      |-> (out_exp == $past(in_exp)) && (out_mant <= $past(in_mant))); // R6
  AST_CARRY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp != $past(in_exp))
      |-> (out_mant == {1'b1, {(MANT_W-1){1'b0}}})); // R8

endmodule

// File: tb/test_fp_round_unit.sv
module test_fp_round_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic [2:0]  in_grs = '0;
  logic [1:0]  in_prec = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid, out_sign, out_inexact;
  logic [15:0] out_exp;
  logic [63:0] out_mant;
  logic [2:0]  out_grs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_round_unit i_fp_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_grs(in_grs), .in_prec(in_prec),
    .in_mode(in_mode), .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant), .out_grs(out_grs),
    .out_inexact(out_inexact)
  );

  // reference: {exp[15:0], mant[63:0], inexact}
  function automatic logic [80:0] ref_round(logic s, logic [15:0] e, logic [63:0] m,
                                            logic [2:0] g, logic [1:0] p, logic [1:0] md);
    int sh;
    logic [66:0] v, q, rem, half;
    logic inex, up;
    logic [63:0] rm;
    logic [15:0] re;
    sh   = (p == 2'd0) ? 3 : (p == 2'd1) ? 43 : 14;
    v    = {m, g};
    q    = v >> sh;
    rem  = v & ((67'd1 << sh) - 67'd1);
    half = 67'd1 << (sh - 1);
    inex = (rem != 67'd0);
    case (md)
      2'd0:    up = (rem > half) || (rem == half && q[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = inex && s;
      default: up = inex && !s;
    endcase
    q = q + {66'd0, up};
    if ((q >> (67 - sh)) != 67'd0) begin
      rm = 64'h8000_0000_0000_0000;
      re = e + 16'd1;
    end else begin
      rm = 64'(q << (sh - 3));
      re = e;
    end
    return {re, rm, inex};
  endfunction

  task automatic check_out(string tag, logic s, logic [80:0] exp_v);
    checks++;
    if (!out_valid || out_sign !== s || out_grs !== 3'b000 ||
        {out_exp, out_mant, out_inexact} !== exp_v) begin
      errors++;
      $display("FAIL %s: got v=%0b s=%0b grs=%0b exp=%h mant=%h inex=%0b, expected s=%0b exp=%h mant=%h inex=%0b",
               tag, out_valid, out_sign, out_grs, out_exp, out_mant, out_inexact,
               s, exp_v[80:65], exp_v[64:1], exp_v[0]);
    end
  endtask

  task automatic apply(string tag, logic s, logic [15:0] e, logic [63:0] m,
                       logic [2:0] g, logic [1:0] p, logic [1:0] md);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = e; in_mant = m;
    in_grs = g; in_prec = p; in_mode = md;
    @(negedge clk);
    check_out(tag, s, ref_round(s, e, m, g, p, md));
  endtask

  task automatic check_idle(string tag);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid=%0b expected 0", tag, out_valid);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1F2E);
    repeat (3) @(negedge clk);
    check_idle("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10 idle after reset");

    // R8 carry from all-ones at every precision
    apply("R8 ext carry",  1'b0, 16'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001, 2'd0, 2'd3);
    apply("R8 sgl carry",  1'b0, 16'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, 2'd1, 2'd0);
    apply("R8 dbl carry",  1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, 2'd2, 2'd2);
    // R5 ties-to-even at single
    apply("R5 tie even stays", 1'b0, 16'h10, 64'h8000_0080_0000_0000, 3'b000, 2'd1, 2'd0);
    apply("R5 tie odd rounds", 1'b0, 16'h10, 64'h8000_0180_0000_0000, 3'b000, 2'd1, 2'd0);
    apply("R5 ext tie even",   1'b0, 16'h10, 64'h8000_0000_0000_0002, 3'b100, 2'd0, 2'd0);
    apply("R5 ext above half", 1'b0, 16'h10, 64'h8000_0000_0000_0002, 3'b101, 2'd0, 2'd0);
    // R2 sticky from low word / incoming field at single
    apply("R2 sgl sticky low word", 1'b0, 16'h20, 64'h8000_0000_0000_0001, 3'b000, 2'd1, 2'd3);
    apply("R2 sgl sticky grs",      1'b0, 16'h20, 64'h8000_0000_0000_0000, 3'b010, 2'd1, 2'd3);
    apply("R2 sgl tie broken",      1'b0, 16'h20, 64'h8000_0080_0000_0001, 3'b000, 2'd1, 2'd0);
    // R3 double guard/round positions, code 3 as double
    apply("R3 dbl guard",    1'b0, 16'h30, 64'h8000_0000_0000_0400, 3'b000, 2'd2, 2'd0);
    apply("R3 dbl round",    1'b0, 16'h30, 64'h8000_0000_0000_0200, 3'b000, 2'd3, 2'd0);
    apply("R3 dbl sticky",   1'b1, 16'h30, 64'h8000_0000_0000_0001, 3'b000, 2'd3, 2'd2);
    // R4 exact
    apply("R4 exact ext",    1'b1, 16'h1234, 64'hDEAD_BEEF_0123_4567, 3'b000, 2'd0, 2'd3);
    apply("R4 exact sgl",    1'b0, 16'h1234, 64'hABCD_EF00_0000_0000, 3'b000, 2'd1, 2'd2);
    // R6 toward zero
    apply("R6 zero trunc",   1'b0, 16'h55, 64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 2'd1, 2'd1);
    // R7 directed
    apply("R7 plus neg",     1'b1, 16'h55, 64'h8000_0000_0000_0001, 3'b000, 2'd2, 2'd3);
    apply("R7 minus neg",    1'b1, 16'h55, 64'h8000_0000_0000_0001, 3'b000, 2'd2, 2'd2);
    apply("R7 minus pos",    1'b0, 16'h55, 64'h8000_0000_0000_0001, 3'b000, 2'd2, 2'd2);

    // R10 gap cycle
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_idle("R10 gap");

    // R1 R9 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] m;
      logic [31:0] sel;
      sel = $urandom;
      m = {$urandom, $urandom};
      if (sel[3:0] == 4'd0) m = 64'hFFFF_FFFF_FFFF_FFFF;
      else if (sel[3:0] == 4'd1) m = m | 64'hFFFF_FF00_0000_0000;
      else if (sel[3:0] == 4'd2) m = m | 64'hFFFF_FFFF_FFFF_F800;
      else if (sel[3:0] == 4'd3) m = m & 64'hFFFF_FFFF_FFFF_F800;
      apply("R1 R9 random", sel[4], 16'($urandom), m, 3'(sel[7:5]),
            2'(sel[9:8]), 2'(sel[11:10]));
    end

    in_valid = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule